// File: doc/BRIEF.md
# Display-List Address Sequencer with Return Stack

This block generates the fetch address for a vector display processor's display list. It holds a 14-bit program counter, drives it on its outputs, and moves it under five operations: reset, increment, jump, subroutine call and subroutine return. A three-entry return stack of full 14-bit addresses sits inside the block. The stack has no path to external memory.

The control side is made of an active-low strobe, a three-bit operation code, an increment-hold line and a slow system tick line. All of these arrive asynchronously to the block's clock. The strobe and the tick are synchronized and edge-detected internally, so every state change happens on one rising edge of `clk`.

A jump or call loads the upper thirteen target bits as soon as the strobe acts. Bit 0 waits for a tick rising edge that arrives while the strobe is still held low. A strobe whose operation code does not enable it leaves the block untouched.

Top module: `dl_addr_seq`

## Requirements
- R1: A low `rst_n` at a rising `clk` edge clears the program counter and the stack pointer to zero, so `pc` reads 0x0000 after that edge.
- R2: A tick rising edge while the strobe is released and `inc_hold` is low adds one to `pc`, and 0x3FFF wraps to 0x0000.
- R3: While `inc_hold` is high, tick rising edges leave `pc` unchanged.
- R4: A strobe falling edge with `op_code` = 3'b101 (jump) loads `pc[13:1]` from `tgt[13:1]` and leaves `pc[0]` as it was.
- R5: After a jump or call, the target's bit 0 is held pending and is written to `pc[0]` at the first tick rising edge while the strobe stays low. If the strobe is released before such an edge, `pc[0]` keeps its old value.
- R6: A strobe falling edge with `op_code` = 3'b110 (call) stores the current `pc` in the stack entry at the pointer, advances the pointer, and loads the target as in R4 and R5.
- R7: A strobe falling edge with `op_code` = 3'b111 (return) steps the pointer back and loads the full 14-bit `pc` at once from the entry it then selects.
- R8: A strobe falling edge while `op_code[2]` is 0, or with `op_code` = 3'b100, changes neither `pc` nor the stack pointer.
- R9: The stack pointer counts modulo 3. A fourth call without a return overwrites entry 0, and a return from pointer 0 reads entry 2.
- R10: A change on `strobe_n` or `tick` takes effect at the third rising `clk` edge after the new level is first presented; `op_code`, `tgt` and `inc_hold` are used as they stand at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; every state change happens on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of counter and stack pointer |
| strobe_n | input | 1 | Asynchronous active-low operation strobe |
| tick | input | 1 | Asynchronous system tick line (increment and bit-0 timing) |
| inc_hold | input | 1 | High blocks increments |
| op_code | input | 3 | Bit 2 enables the strobe; bits 1:0 select none, jump, call or return |
| tgt | input | 14 | Jump and call target address |
| pc | output | 14 | Current display-list address |

## Verification
Some rules are checked by the assertions on every cycle. `pc` holds still when no operation event fires. An increment adds exactly one. A jump or call loads the upper bits and keeps bit 0. Each call or return moves the stack pointer by one place modulo three. A disabled strobe never moves anything, and reset clears both counters. Only the bench's scenarios can show the things that span many cycles: that a return brings back the address stored by the matching call, that a fourth call overwrites the oldest entry and a return from an empty stack reads the last one, that bit 0 waits for the tick, and that each action lands exactly three clock edges after the input changed.

// File: rtl/dlseq_pkg.sv
// Package: shared types and defaults for the display-list address sequencer.
// Assumes: op_code[1:0] selects the operation and op_code[2] enables the strobe.
package dlseq_pkg;

    localparam int DL_AW    = 14;
    localparam int DL_DEPTH = 3;

    typedef enum logic [1:0] {
        OPK_NONE = 2'b00,
        OPK_JUMP = 2'b01,
        OPK_CALL = 2'b10,
        OPK_RET  = 2'b11
    } dl_op_e;

    typedef struct packed {
        logic jump;
        logic call;
        logic ret;
    } dl_ops_t;

endpackage

// File: rtl/dlseq_sync.sv
// Module: dlseq_sync
// Brings one asynchronous line into the clk domain through STAGES flops, then
// reports its settled level and single-cycle rise and fall pulses.
// Assumes: RST_VAL is the line's idle level, so reset creates no phantom edge.
module dlseq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    // Remember the settled level of the previous cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= RST_VAL;
        end else begin
            prev <= chain[STAGES-1];
        end
    end

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~prev;
    assign fall = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/dlseq_stack.sv
// Module: dlseq_stack
// Internal return stack of DEPTH words of AW bits. The pointer counts modulo
// DEPTH in both directions, with no overflow or underflow flag.
// Assumes: push and pop are never high together.
module dlseq_stack #(
    parameter int AW    = 14,
    parameter int DEPTH = 3,
    localparam int SPW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic           pop,
    input  logic [AW-1:0]  wdata,
    output logic [AW-1:0]  rdata,
    output logic [SPW-1:0] sp
);

    logic [AW-1:0]  mem [DEPTH];
    logic [SPW-1:0] sp_inc;
    logic [SPW-1:0] sp_dec;

    // Work out the neighbouring pointer values with modulo-DEPTH wrap.
    always_comb begin
        sp_inc = (sp == SPW'(DEPTH - 1)) ? '0 : sp + SPW'(1);
        sp_dec = (sp == '0) ? SPW'(DEPTH - 1) : sp - SPW'(1);
    end

    // Move the pointer on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= '0;
        end else if (push) begin
            sp <= sp_inc;
        end else if (pop) begin
            sp <= sp_dec;
        end
    end

    // One storage word per level; only the addressed word takes a push.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[gi] <= '0;
            end else if (push && (sp == SPW'(gi))) begin
                mem[gi] <= wdata;
            end
        end
    end

    // A return reads the entry just below the current pointer.
    assign rdata = mem[sp_dec];

endmodule

// File: rtl/dlseq_pc.sv
// Module: dlseq_pc
// Program counter register with split loading. A jump or call writes bits
// AW-1:1 at once and parks bit 0. The parked bit lands on a later tick edge
// or is dropped when the strobe is released.
// Assumes: at most one of ld_hi, ld_all, b0_go and inc_go is high per cycle.
module dlseq_pc #(
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_hi,
    input  logic [AW-1:0] tgt,
    input  logic          ld_all,
    input  logic [AW-1:0] ret_addr,
    input  logic          b0_go,
    input  logic          inc_go,
    input  logic          stb_rise,
    output logic          pend,
    output logic [AW-1:0] pc
);

    logic pbit;

    // Update the counter by the one operation active this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (ld_hi) begin
            pc[AW-1:1] <= tgt[AW-1:1];
        end else if (ld_all) begin
            pc <= ret_addr;
        end else if (b0_go) begin
            pc[0] <= pbit;
        end else if (inc_go) begin
            pc <= pc + AW'(1);
        end
    end

    // Track whether a target bit 0 is still waiting for its tick edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (ld_hi) begin
            pend <= 1'b1;
        end else if (ld_all || b0_go || stb_rise) begin
            pend <= 1'b0;
        end
    end

    // Capture the target's bit 0 when the upper bits load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pbit <= 1'b0;
        end else if (ld_hi) begin
            pbit <= tgt[0];
        end
    end

endmodule

// File: rtl/dl_addr_seq.sv
// Module: dl_addr_seq (top)
// Display-list address sequencer: synchronizes the strobe and tick lines,
// decodes enabled operations, and drives the program counter and return stack.
// Assumes: op_code, tgt and inc_hold are stable while a strobe is acted on.
module dl_addr_seq #(
    parameter int AW          = dlseq_pkg::DL_AW,
    parameter int DEPTH       = dlseq_pkg::DL_DEPTH,
    parameter int SYNC_STAGES = 2,
    localparam int SPW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_n,
    input  logic          tick,
    input  logic          inc_hold,
    input  logic [2:0]    op_code,
    input  logic [AW-1:0] tgt,
    output logic [AW-1:0] pc
);

    import dlseq_pkg::*;

    logic           stb_lvl, stb_rise, stb_fall;
    logic           tick_lvl, tick_rise, tick_fall;
    dl_ops_t        ops;
    dl_op_e         kind;
    logic           jmp_go, call_go, ret_go, inc_go, b0_go;
    logic           pend;
    logic [AW-1:0]  ret_addr;
    logic [SPW-1:0] sp;

    dlseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stb_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (strobe_n),
        .lvl  (stb_lvl),
        .rise (stb_rise),
        .fall (stb_fall)
    );

    dlseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tick_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (tick),
        .lvl  (tick_lvl),
        .rise (tick_rise),
        .fall (tick_fall)
    );

    // Decode the strobe's falling edge into an enabled operation.
    always_comb begin
        kind     = dl_op_e'(op_code[1:0]);
        ops      = '0;
        if (stb_fall && op_code[2]) begin
            unique case (kind)
                OPK_JUMP: ops.jump = 1'b1;
                OPK_CALL: ops.call = 1'b1;
                OPK_RET:  ops.ret  = 1'b1;
                default:  ops      = '0;
            endcase
        end
    end

    // Turn tick edges into either a parked bit-0 load or an increment.
    always_comb begin
        jmp_go  = ops.jump;
        call_go = ops.call;
        ret_go  = ops.ret;
        b0_go   = tick_rise && !stb_lvl && pend;
        inc_go  = tick_rise && stb_lvl && !inc_hold;
    end

    dlseq_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
        .clk  (clk),
        .rst_n(rst_n),
        .push (call_go),
        .pop  (ret_go),
        .wdata(pc),
        .rdata(ret_addr),
        .sp   (sp)
    );

    dlseq_pc #(.AW(AW)) u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_hi   (jmp_go || call_go),
        .tgt     (tgt),
        .ld_all  (ret_go),
        .ret_addr(ret_addr),
        .b0_go   (b0_go),
        .inc_go  (inc_go),
        .stb_rise(stb_rise),
        .pend    (pend),
        .pc      (pc)
    );

endmodule

// File: rtl/dl_addr_seq_chk.sv
// Module: dl_addr_seq_chk
// Cycle-level rules of the address sequencer, bound into every instance.
// Assumes: connected to the top's internal event and pointer signals.
module dl_addr_seq_chk #(
    parameter int AW    = 14,
    parameter int DEPTH = 3,
    localparam int SPW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [AW-1:0]  pc,
    input logic [SPW-1:0] sp,
    input logic [AW-1:0]  tgt,
    input logic [2:0]     op_code,
    input logic           inc_hold,
    input logic           stb_fall,
    input logic           stb_lvl,
    input logic           tick_rise,
    input logic           jmp_go,
    input logic           call_go,
    input logic           ret_go,
    input logic           inc_go,
    input logic           b0_go
);

    logic seen  = 1'b0;
    logic rst_d = 1'b1;

    // Check the cycle after a reset edge shows cleared state.
    always_ff @(posedge clk) begin
        seen  <= 1'b1;
        rst_d <= rst_n;
        if (seen && !rst_d) begin
            AST_RESET_CLEARS: assert (pc == '0 && sp == '0); // R1
        end
    end

    AST_INC_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        inc_go |=> pc == $past(pc) + AW'(1)); // R2

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_rise && stb_lvl && inc_hold) |=> $stable(pc)); // R3

    AST_LOAD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_go || call_go) |=> (pc[AW-1:1] == $past(tgt[AW-1:1])) && (pc[0] == $past(pc[0]))); // R4

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc_go || jmp_go || call_go || ret_go || b0_go) |=> $stable(pc)); // R5

    AST_CALL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        call_go |=> sp == (($past(sp) == SPW'(DEPTH - 1)) ? '0 : $past(sp) + SPW'(1))); // R6

    AST_RET_RETREAT: assert property (@(posedge clk) disable iff (!rst_n)
        ret_go |=> sp == (($past(sp) == '0) ? SPW'(DEPTH - 1) : $past(sp) - SPW'(1))); // R7

    AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_fall && (!op_code[2] || op_code[1:0] == 2'b00) && !b0_go) |=> $stable(pc) && $stable(sp)); // R8

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sp < SPW'(DEPTH)); // R9

endmodule

bind dl_addr_seq dl_addr_seq_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc       (pc),
    .sp       (sp),
    .tgt      (tgt),
    .op_code  (op_code),
    .inc_hold (inc_hold),
    .stb_fall (stb_fall),
    .stb_lvl  (stb_lvl),
    .tick_rise(tick_rise),
    .jmp_go   (jmp_go),
    .call_go  (call_go),
    .ret_go   (ret_go),
    .inc_go   (inc_go),
    .b0_go    (b0_go)
);

// File: tb/dl_addr_seq_test.sv
// Bench: behavioural reference model compared with pc on every clock, plus
// scenario checks with hand-computed addresses.
module dl_addr_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe_n = 1'b1;
    logic        tick = 1'b0;
    logic        inc_hold = 1'b0;
    logic [2:0]  op_code = 3'b000;
    logic [13:0] tgt = '0;
    logic [13:0] pc;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    string cur_req = "R1";
    bit done = 0;

    // Reference model state.
    int m_pc = 0;
    int m_sp = 0;
    int m_stk[3];
    bit m_pend = 0;
    bit m_pbit = 0;
    bit sq[$];
    bit tq[$];

    always #4 clk = ~clk;

    dl_addr_seq uut (
        .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .tick(tick),
        .inc_hold(inc_hold), .op_code(op_code), .tgt(tgt), .pc(pc)
    );

    // Reference model: each line acts two clk edges after it is first sampled.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 0; m_sp = 0; m_pend = 0; m_pbit = 0;
            foreach (m_stk[i]) m_stk[i] = 0;
            sq = '{1'b1, 1'b1, 1'b1, 1'b1};
            tq = '{1'b0, 1'b0, 1'b0, 1'b0};
        end else begin
            bit s_now, s_old, t_now, t_old, fall, srise, trise, ena;
            s_now = sq[2]; s_old = sq[1]; t_now = tq[2]; t_old = tq[1];
            fall  = !s_now && s_old;
            srise = s_now && !s_old;
            trise = t_now && !t_old;
            ena   = op_code[2] && (op_code[1:0] != 2'b00);
            if (fall && ena) begin
                if (op_code[1:0] == 2'b11) begin
                    m_sp = (m_sp + 2) % 3;
                    m_pc = m_stk[m_sp];
                    m_pend = 0;
                end else begin
                    if (op_code[1:0] == 2'b10) begin
                        m_stk[m_sp] = m_pc;
                        m_sp = (m_sp + 1) % 3;
                    end
                    m_pc = (int'(tgt) & 'h3FFE) | (m_pc & 1);
                    m_pend = 1;
                    m_pbit = tgt[0];
                end
            end else if (trise && !s_now && m_pend) begin
                m_pc = (m_pc & 'h3FFE) | int'(m_pbit);
                m_pend = 0;
            end else if (trise && s_now && !inc_hold) begin
                m_pc = (m_pc + 1) & 'h3FFF;
            end
            if (srise) m_pend = 0;
            sq.push_back(strobe_n); void'(sq.pop_front());
            tq.push_back(tick);     void'(tq.pop_front());
        end
    end

    // Compare the design with the model away from the active edge.
    always @(negedge clk) begin
        if (!done && cyc > 0) begin
            checks++;
            if (int'(pc) != m_pc) begin
                fails++;
                $display("FAIL %s model compare: pc=%h expected=%h", cur_req, pc, m_pc[13:0]);
            end
        end
    end

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected<=%0d", cyc, 100000);
            finish_up();
        end
    end

    task automatic finish_up();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic expect_pc(input logic [13:0] exp, input string req);
        checks++;
        if (pc !== exp) begin
            fails++;
            $display("FAIL %s: pc=%h expected=%h", req, pc, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_pulse();
        tick = 1'b1; wait_n(4);
        tick = 1'b0; wait_n(4);
    endtask

    task automatic strobe_op(input logic [2:0] op, input logic [13:0] t, input bit with_tick);
        op_code = op; tgt = t;
        wait_n(1);
        strobe_n = 1'b0;
        wait_n(3);
        if (with_tick) begin
            tick = 1'b1; wait_n(4);
            tick = 1'b0;
        end
        wait_n(4);
        strobe_n = 1'b1;
        wait_n(4);
        op_code = 3'b000;
    endtask

    initial begin
        wait_n(4);
        cur_req = "R1";
        expect_pc(14'h0000, "R1 reset");
        rst_n = 1'b1;
        wait_n(2);

        cur_req = "R2";
        repeat (5) tick_pulse();
        expect_pc(14'h0005, "R2 increment");

        cur_req = "R3";
        inc_hold = 1'b1;
        repeat (3) tick_pulse();
        expect_pc(14'h0005, "R3 hold");
        inc_hold = 1'b0;

        cur_req = "R4";
        strobe_op(3'b101, 14'h2AAA, 0);
        expect_pc(14'h2AAB, "R4 R5 jump without tick keeps bit0");
        cur_req = "R5";
        strobe_op(3'b101, 14'h1235, 1);
        expect_pc(14'h1235, "R5 jump bit0 on tick");

        cur_req = "R8";
        strobe_op(3'b001, 14'h0F0F, 1);
        expect_pc(14'h1235, "R8 disabled strobe");
        strobe_op(3'b100, 14'h0F0F, 1);
        expect_pc(14'h1235, "R8 enabled no-op code");

        cur_req = "R6";
        strobe_op(3'b110, 14'h0101, 1);
        expect_pc(14'h0101, "R6 call target");
        repeat (2) tick_pulse();
        expect_pc(14'h0103, "R6 run in subroutine");
        strobe_op(3'b110, 14'h0201, 1);
        expect_pc(14'h0201, "R6 nested call");
        cur_req = "R7";
        strobe_op(3'b111, 14'h3FFF, 0);
        expect_pc(14'h0103, "R7 inner return");
        strobe_op(3'b111, 14'h0000, 1);
        expect_pc(14'h1235, "R7 outer return");

        cur_req = "R2";
        strobe_op(3'b101, 14'h3FFE, 1);
        repeat (2) tick_pulse();
        expect_pc(14'h0000, "R2 wrap");

        cur_req = "R9";
        strobe_op(3'b110, 14'h0011, 1);
        strobe_op(3'b110, 14'h0021, 1);
        strobe_op(3'b110, 14'h0031, 1);
        strobe_op(3'b110, 14'h0041, 1);
        expect_pc(14'h0041, "R9 fourth call");
        strobe_op(3'b111, 14'h0000, 0);
        expect_pc(14'h0031, "R9 overwritten entry");
        strobe_op(3'b111, 14'h0000, 0);
        expect_pc(14'h0021, "R9 pop wraps");
        strobe_op(3'b111, 14'h0000, 0);
        expect_pc(14'h0011, "R9 third pop");
        strobe_op(3'b111, 14'h0000, 0);
        expect_pc(14'h0031, "R9 empty pop");
        strobe_op(3'b111, 14'h0000, 0);
        expect_pc(14'h0021, "R9 second wrap");

        cur_req = "R10";
        op_code = 3'b101; tgt = 14'h0500;
        wait_n(1);
        strobe_n = 1'b0;
        wait_n(2);
        expect_pc(14'h0021, "R10 not yet after two edges");
        wait_n(1);
        expect_pc(14'h0501, "R10 applied on third edge");
        wait_n(3);
        strobe_n = 1'b1;
        wait_n(4);
        op_code = 3'b000;

        cur_req = "R1";
        rst_n = 1'b0;
        wait_n(2);
        expect_pc(14'h0000, "R1 reset mid-run");
        rst_n = 1'b1;
        wait_n(4);
        finish_up();
    end

endmodule